// File: doc/BRIEF.md
# Load-Store Ordering Queue with Store Forwarding

This block holds the in-flight memory operations of an out-of-order core in two separate queues, one for loads and one for stores. The core dispatches memory operations in program order, each tagged with an age. Store addresses and store data are resolved later, by age tag. A load may be issued as soon as its own address is known, even while some older store addresses are still unknown. At issue the unit searches the store queue: if the youngest older store known to hit the same word already holds its data, that data is returned in the same cycle in place of a memory read. If that store has no data yet, the load is told to wait.

When a store address resolves, the unit looks for younger loads that have already issued to that word without taking their value from a store placed between them. If it finds any, it reports a memory ordering violation one cycle later, together with the age of the oldest such load, so that the core can replay from that load. Retirement removes the oldest operation of either queue. A retiring store writes memory through a plain write port, so stores reach memory strictly in program order.

Dispatch and retirement use valid/ready handshakes. A dispatch with `disp_valid` high and `disp_ready` low is not taken and must be held by the core. A retirement only happens when `ret_ready` is high, which it is only when the oldest operation has finished. Address, data and load-issue inputs are single-cycle pulses, and the core must apply them only to operations it has already dispatched.

Top module: `lsq_fwd`

## Requirements
- R1: `disp_ready` depends only on the queue chosen by `disp_is_store` (1 = store, 0 = load). It is low exactly when that queue holds 4 entries. A dispatch offered while `disp_ready` is low is not taken and takes no queue slot.
- R2: Retirement takes the operation with the oldest age across both queues. `ret_ready` is high only if that operation is a store with both its address and its data resolved, or a load that has issued. A retired store drives `mem_wr_valid` with its address and data in the same cycle. A retired load leaves `mem_wr_valid` low.
- R3: A load issue (`ld_valid`) whose youngest older store with a matching resolved address holds its data returns `ld_fwd_hit`=1 and that store's data in the same cycle. Addresses match only when they are equal as whole words.
- R4: When several older stores match the load address, the youngest of them is the one selected.
- R5: Stores younger than the load, and stores whose resolved address differs from the load address, have no effect on the forwarding result.
- R6: If the selected store has no data yet, `ld_fwd_wait`=1 and `ld_fwd_hit`=0. The load is not recorded as issued.
- R7: A load may issue while older store addresses are unresolved. If no resolved older store matches, both `ld_fwd_hit` and `ld_fwd_wait` are 0.
- R8: In the cycle after a store address resolves, `viol_valid`=1 if any younger issued load has the same address, and `viol_age` gives the oldest such load.
- R9: A load that took its value from a store younger than the resolving store is not flagged.
- R10: Loads older than the resolving store, loads not yet issued, and loads issued to other addresses are not flagged.
- R11: After reset both queues are empty, `disp_ready` is high for either kind of operation, and `ret_ready` and `viol_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Target queue has room |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_age | input | AGE_W | Age tag of the dispatched operation |
| sta_valid | input | 1 | Store address resolves |
| sta_age | input | AGE_W | Age tag of that store |
| sta_addr | input | ADDR_W | Resolved word address |
| std_valid | input | 1 | Store data arrives |
| std_age | input | AGE_W | Age tag of that store |
| std_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load issues |
| ld_age | input | AGE_W | Age tag of the issuing load |
| ld_addr | input | ADDR_W | Load word address |
| ld_fwd_hit | output | 1 | Data is forwarded from a store |
| ld_fwd_wait | output | 1 | Matching store has no data yet; retry the load |
| ld_fwd_data | output | DATA_W | Forwarded data |
| ret_valid | input | 1 | Core retires the oldest operation |
| ret_ready | output | 1 | Oldest operation is complete |
| mem_wr_valid | output | 1 | Memory write from a retiring store |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| viol_valid | output | 1 | Ordering violation found |
| viol_age | output | AGE_W | Age tag of the oldest offending load |

## Verification
The hardest situation to create is a violation report that has to decide which loads count: an older load, younger loads in different issue states, and a store lying between the load and the resolving store all bear on the answer. The bench sweeps every combination of issue state (not issued, issued to the resolving address, issued elsewhere) over three younger loads, with an older load to the same word always present. It computes the expected oldest offender arithmetically. For forwarding, it sweeps all 256 ways in which four older stores can match the address and hold data, and checks the selected youngest matching store for each.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  parameter int AGE_W = 4;
  typedef logic [AGE_W-1:0] age_t;
  typedef enum logic {SRC_LOAD = 1'b0, SRC_STORE = 1'b1} ret_src_e;

  // true when tag a is older than tag b (modular distance, in-flight < 2**(AGE_W-1))
  function automatic logic is_older(input age_t a, input age_t b);
    age_t d;
    d = a - b;
    return d[AGE_W-1];
  endfunction
endpackage

// File: rtl/lsq_sq.sv
module lsq_sq
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  age_t              alloc_age,
  input  logic              addr_set,
  input  age_t              addr_age,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_set,
  input  age_t              data_age,
  input  logic [DATA_W-1:0] data_val,
  input  logic              pop,
  input  age_t              look_age,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              full,
  output logic              empty,
  output age_t              head_age,
  output logic              head_ready,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              fwd_found,
  output logic              fwd_has_data,
  output logic [DATA_W-1:0] fwd_data,
  output age_t              fwd_age
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0]  v_q, ak_q, dk_q;
  age_t              age_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign head_age   = age_q[head_q];
  assign head_ready = ak_q[head_q] & dk_q[head_q];
  assign head_addr  = addr_q[head_q];
  assign head_data  = data_q[head_q];

  // walk from oldest to youngest; the last hit is the youngest older match
  always_comb begin
    logic [PTR_W-1:0] idx;
    fwd_found    = 1'b0;
    fwd_has_data = 1'b0;
    fwd_data     = '0;
    fwd_age      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_q + PTR_W'(i);
      if (v_q[idx] && ak_q[idx] && addr_q[idx] == look_addr &&
          is_older(age_q[idx], look_age)) begin
        fwd_found    = 1'b1;
        fwd_has_data = dk_q[idx];
        fwd_data     = data_q[idx];
        fwd_age      = age_q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      ak_q   <= '0;
      dk_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age_q[i]  <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (addr_set && v_q[i] && age_q[i] == addr_age) begin
          ak_q[i]   <= 1'b1;
          addr_q[i] <= addr_val;
        end
        if (data_set && v_q[i] && age_q[i] == data_age) begin
          dk_q[i]   <= 1'b1;
          data_q[i] <= data_val;
        end
      end
      if (pop) begin
        v_q[head_q] <= 1'b0;
        head_q      <= head_q + 1'b1;
      end
      if (alloc) begin
        v_q[tail_q]   <= 1'b1;
        ak_q[tail_q]  <= 1'b0;
        dk_q[tail_q]  <= 1'b0;
        age_q[tail_q] <= alloc_age;
        tail_q        <= tail_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/lsq_lq.sv
module lsq_lq
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  age_t              alloc_age,
  input  logic              issue,
  input  age_t              issue_age,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_fwd,
  input  age_t              issue_src,
  input  logic              pop,
  input  logic              chk_valid,
  input  age_t              chk_age,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              full,
  output logic              empty,
  output age_t              head_age,
  output logic              head_issued,
  output logic              viol_hit,
  output age_t              viol_age
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0]  v_q, iss_q, fwd_q;
  age_t              age_q  [DEPTH];
  age_t              src_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  assign full        = (cnt_q == CNT_W'(DEPTH));
  assign empty       = (cnt_q == '0);
  assign head_age    = age_q[head_q];
  assign head_issued = iss_q[head_q];

  // oldest first; a load issuing in this very cycle is seen with its live fields
  always_comb begin
    logic [PTR_W-1:0]  idx;
    logic              now, done, fw;
    logic [ADDR_W-1:0] a;
    age_t              src;
    viol_hit = 1'b0;
    viol_age = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx  = head_q + PTR_W'(i);
      now  = issue && !iss_q[idx] && age_q[idx] == issue_age;
      done = iss_q[idx] || now;
      a    = now ? issue_addr : addr_q[idx];
      fw   = now ? issue_fwd  : fwd_q[idx];
      src  = now ? issue_src  : src_q[idx];
      if (chk_valid && !viol_hit && v_q[idx] && done && a == chk_addr &&
          is_older(chk_age, age_q[idx]) && !(fw && is_older(chk_age, src))) begin
        viol_hit = 1'b1;
        viol_age = age_q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      iss_q  <= '0;
      fwd_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age_q[i]  <= '0;
        src_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (issue && v_q[i] && age_q[i] == issue_age) begin
          iss_q[i]  <= 1'b1;
          addr_q[i] <= issue_addr;
          fwd_q[i]  <= issue_fwd;
          src_q[i]  <= issue_src;
        end
      end
      if (pop) begin
        v_q[head_q] <= 1'b0;
        head_q      <= head_q + 1'b1;
      end
      if (alloc) begin
        v_q[tail_q]   <= 1'b1;
        iss_q[tail_q] <= 1'b0;
        fwd_q[tail_q] <= 1'b0;
        age_q[tail_q] <= alloc_age;
        tail_q        <= tail_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/lsq_fwd.sv
module lsq_fwd
  import lsq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic              disp_is_store,
  input  logic [AGE_W-1:0]  disp_age,
  input  logic              sta_valid,
  input  logic [AGE_W-1:0]  sta_age,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [AGE_W-1:0]  std_age,
  input  logic [DATA_W-1:0] std_data,
  input  logic              ld_valid,
  input  logic [AGE_W-1:0]  ld_age,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_fwd_hit,
  output logic              ld_fwd_wait,
  output logic [DATA_W-1:0] ld_fwd_data,
  input  logic              ret_valid,
  output logic              ret_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              viol_valid,
  output logic [AGE_W-1:0]  viol_age
);
  logic sq_full, sq_empty, sq_head_ready, lq_full, lq_empty, lq_head_issued;
  logic fwd_found, fwd_has_data, viol_hit;
  logic [ADDR_W-1:0] sq_head_addr;
  logic [DATA_W-1:0] sq_head_data, fwd_data;
  age_t sq_head_age, lq_head_age, fwd_age, viol_hit_age;
  ret_src_e ret_src;
  logic disp_fire, ret_fire, ld_issue;

  assign disp_ready = disp_is_store ? !sq_full : !lq_full;
  assign disp_fire  = disp_valid && disp_ready;

  assign ret_src   = (!sq_empty && (lq_empty || is_older(sq_head_age, lq_head_age)))
                     ? SRC_STORE : SRC_LOAD;
  assign ret_ready = (ret_src == SRC_STORE) ? sq_head_ready : (!lq_empty && lq_head_issued);
  assign ret_fire  = ret_valid && ret_ready;

  assign mem_wr_valid = ret_fire && ret_src == SRC_STORE;
  assign mem_wr_addr  = sq_head_addr;
  assign mem_wr_data  = sq_head_data;

  assign ld_fwd_hit  = ld_valid && fwd_found && fwd_has_data;
  assign ld_fwd_wait = ld_valid && fwd_found && !fwd_has_data;
  assign ld_fwd_data = ld_fwd_hit ? fwd_data : '0;
  assign ld_issue    = ld_valid && !ld_fwd_wait;

  lsq_sq #(.DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sq (
    .clk, .rst_n,
    .alloc(disp_fire && disp_is_store), .alloc_age(disp_age),
    .addr_set(sta_valid), .addr_age(sta_age), .addr_val(sta_addr),
    .data_set(std_valid), .data_age(std_age), .data_val(std_data),
    .pop(ret_fire && ret_src == SRC_STORE),
    .look_age(ld_age), .look_addr(ld_addr),
    .full(sq_full), .empty(sq_empty), .head_age(sq_head_age),
    .head_ready(sq_head_ready), .head_addr(sq_head_addr), .head_data(sq_head_data),
    .fwd_found, .fwd_has_data, .fwd_data, .fwd_age
  );

  lsq_lq #(.DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W)) u_lq (
    .clk, .rst_n,
    .alloc(disp_fire && !disp_is_store), .alloc_age(disp_age),
    .issue(ld_issue), .issue_age(ld_age), .issue_addr(ld_addr),
    .issue_fwd(ld_fwd_hit), .issue_src(fwd_age),
    .pop(ret_fire && ret_src == SRC_LOAD),
    .chk_valid(sta_valid), .chk_age(sta_age), .chk_addr(sta_addr),
    .full(lq_full), .empty(lq_empty), .head_age(lq_head_age),
    .head_issued(lq_head_issued), .viol_hit, .viol_age(viol_hit_age)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_age   <= '0;
    end else begin
      viol_valid <= viol_hit;
      viol_age   <= viol_hit ? viol_hit_age : viol_age;
    end
  end
endmodule

// File: rtl/lsq_fwd_chk.sv
module lsq_fwd_chk #(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic disp_valid,
  input logic disp_ready,
  input logic disp_is_store,
  input logic sta_valid,
  input logic ld_valid,
  input logic ld_fwd_hit,
  input logic ld_fwd_wait,
  input logic ret_valid,
  input logic ret_ready,
  input logic mem_wr_valid,
  input logic viol_valid
);
  localparam int CW = $clog2(SQ_DEPTH + LQ_DEPTH + 1) + 1;
  logic [CW-1:0] st_cnt, ld_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cnt <= '0;
      ld_cnt <= '0;
    end else begin
      st_cnt <= st_cnt + CW'(disp_valid && disp_ready && disp_is_store) - CW'(mem_wr_valid);
      ld_cnt <= ld_cnt + CW'(disp_valid && disp_ready && !disp_is_store)
                       - CW'(ret_valid && ret_ready && !mem_wr_valid);
    end
  end

  // R1
  sq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_cnt <= CW'(SQ_DEPTH));
  // R1
  lq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt <= CW'(LQ_DEPTH));
  // R2
  write_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (ret_valid && ret_ready));
  // R6
  hit_wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_fwd_hit && ld_fwd_wait));
  // R3
  fwd_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fwd_hit || ld_fwd_wait) |-> ld_valid);
  // R8
  viol_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> $past(sta_valid));
endmodule

bind lsq_fwd lsq_fwd_chk #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_lsq_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_is_store(disp_is_store), .sta_valid(sta_valid), .ld_valid(ld_valid),
  .ld_fwd_hit(ld_fwd_hit), .ld_fwd_wait(ld_fwd_wait), .ret_valid(ret_valid),
  .ret_ready(ret_ready), .mem_wr_valid(mem_wr_valid), .viol_valid(viol_valid)
);

// File: tb/tb_lsq_fwd.sv
module tb_lsq_fwd;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A = 16'h0040;
  localparam logic [15:0] B = 16'h0044;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 0, disp_is_store = 0, sta_valid = 0, std_valid = 0, ld_valid = 0, ret_valid = 0;
  logic [3:0] disp_age = 0, sta_age = 0, std_age = 0, ld_age = 0;
  logic [15:0] sta_addr = 0, ld_addr = 0;
  logic [31:0] std_data = 0;
  logic disp_ready, ld_fwd_hit, ld_fwd_wait, ret_ready, mem_wr_valid, viol_valid;
  logic [31:0] ld_fwd_data, mem_wr_data;
  logic [15:0] mem_wr_addr;
  logic [3:0] viol_age;

  int checks = 0, failures = 0;
  logic hit_s, wait_s, wv_s;
  logic [31:0] data_s, wd_s;
  logic [15:0] wa_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsq_fwd dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic disp(input logic st, input logic [3:0] age);
    disp_valid = 1; disp_is_store = st; disp_age = age;
    @(posedge clk); #1 disp_valid = 0;
  endtask

  task automatic sta(input logic [3:0] age, input logic [15:0] a);
    sta_valid = 1; sta_age = age; sta_addr = a;
    @(posedge clk); #1 sta_valid = 0;
  endtask

  task automatic std(input logic [3:0] age, input logic [31:0] d);
    std_valid = 1; std_age = age; std_data = d;
    @(posedge clk); #1 std_valid = 0;
  endtask

  task automatic ld(input logic [3:0] age, input logic [15:0] a);
    ld_valid = 1; ld_age = age; ld_addr = a;
    #2 hit_s = ld_fwd_hit; wait_s = ld_fwd_wait; data_s = ld_fwd_data;
    @(posedge clk); #1 ld_valid = 0;
  endtask

  task automatic ret();
    ret_valid = 1;
    #2 wv_s = mem_wr_valid; wa_s = mem_wr_addr; wd_s = mem_wr_data;
    @(posedge clk); #1 ret_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    disp_is_store = 1; #1 check("R11 store ready", disp_ready, 1);
    disp_is_store = 0; #1 check("R11 load ready", disp_ready, 1);
    check("R11 ret_ready", ret_ready, 0);
    check("R11 viol", viol_valid, 0);

    // R1 full store queue, load queue unaffected, overflow dispatch ignored
    for (int i = 0; i < 4; i++) disp(1, 4'(i));
    disp_is_store = 1; #1 check("R1 store full", disp_ready, 0);
    disp_is_store = 0; #1 check("R1 load side free", disp_ready, 1);
    disp(1, 4'd4); // refused
    sta(0, 16'h10); std(0, 32'd1); ret();
    check("R2 head store writes", wv_s, 1);
    disp_is_store = 1; #1 check("R1 refused dispatch took no slot", disp_ready, 1);

    // R2 retire ordering
    do_reset();
    disp(1, 0); disp(0, 1); disp(1, 2);
    std(2, 32'd22); sta(2, 16'h52);
    #1 check("R2 younger ready store waits", ret_ready, 0);
    sta(0, 16'h50);
    #1 check("R2 head lacks data", ret_ready, 0);
    std(0, 32'd11);
    #1 check("R2 head ready", ret_ready, 1);
    ret();
    check("R2 wr valid", wv_s, 1); check("R2 wr addr", wa_s, 16'h50); check("R2 wr data", wd_s, 11);
    #1 check("R2 unissued load blocks", ret_ready, 0);
    ld(1, 16'h52);
    check("R5 younger store not forwarded", hit_s, 0);
    #1 check("R2 issued load ready", ret_ready, 1);
    ret(); check("R2 load retire no write", wv_s, 0);
    ret(); check("R2 second store addr", wa_s, 16'h52); check("R2 second store data", wd_s, 22);
    #1 check("R2 empty", ret_ready, 0);

    // R3 R4 R6 R7 sweep: match mask x data mask over 4 older stores
    for (int m = 0; m < 16; m++) begin
      for (int d = 0; d < 16; d++) begin
        int sel;
        do_reset();
        for (int j = 0; j < 4; j++) disp(1, 4'(j));
        disp(0, 4'd4);
        for (int j = 0; j < 4; j++) begin
          sta(4'(j), m[j] ? A : 16'(16'h20 + j));
          if (d[j]) std(4'(j), 32'(100 + j));
        end
        ld(4, A);
        sel = -1;
        for (int j = 0; j < 4; j++) if (m[j]) sel = j;
        if (sel < 0) begin
          check("R7 no match hit", hit_s, 0); check("R7 no match wait", wait_s, 0);
        end else if (d[sel]) begin
          check("R4 youngest hit", hit_s, 1); check("R3 fwd data", data_s, 32'(100 + sel));
        end else begin
          check("R6 wait", wait_s, 1); check("R6 no hit", hit_s, 0);
        end
      end
    end

    // R5 younger matching store with data ignored
    do_reset();
    disp(1, 0); disp(0, 1); disp(1, 2);
    sta(0, A); std(0, 32'd7); sta(2, A); std(2, 32'd9);
    ld(1, A);
    check("R5 older store chosen", data_s, 7);

    // R8 R10 sweep: older load 0 issued to A, store 1, loads 2..4 in 3 states each
    for (int c = 0; c < 27; c++) begin
      int first, code;
      do_reset();
      disp(0, 0); disp(1, 1); disp(0, 2); disp(0, 3); disp(0, 4);
      ld(0, A);
      if (c == 0) begin check("R7 speculative hit", hit_s, 0); check("R7 speculative wait", wait_s, 0); end
      first = -1; code = c;
      for (int k = 0; k < 3; k++) begin
        int s;
        s = code % 3; code = code / 3;
        if (s == 1) begin ld(4'(2 + k), A); if (first < 0) first = 2 + k; end
        else if (s == 2) ld(4'(2 + k), B);
      end
      sta(1, A);
      check("R8 R10 viol_valid", viol_valid, first >= 0);
      if (first >= 0) check("R8 oldest offender", viol_age, 4'(first));
    end

    // R9 load fed by an intervening store is not flagged
    do_reset();
    disp(1, 0); disp(1, 1); disp(0, 2);
    sta(1, A); std(1, 32'd5);
    ld(2, A); check("R9 fwd from store1", data_s, 5);
    sta(0, A); check("R9 no violation", viol_valid, 0);

    // R6 waiting load not recorded as issued
    do_reset();
    disp(1, 0); disp(1, 1); disp(0, 2);
    sta(1, A); ld(2, A);
    check("R6 waits", wait_s, 1);
    sta(0, A); check("R6 R10 unissued not flagged", viol_valid, 0);
    std(1, 32'd8); ld(2, A);
    check("R3 hit after data", hit_s, 1); check("R3 data after wait", data_s, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule